// File: doc/BRIEF.md
# 8-bit Arithmetic/Logic Unit with Status Flags

This block is the arithmetic core of an accumulator-style processor. A 3-bit operation code selects one of eight operations on two 8-bit operands. The result comes out of combinational logic. A result-write strobe tells the register file whether to store it. Four status flags are produced at the same time: zero, subtract, half-carry and carry. They are captured in a small flag register when the update enable is high.

The flag register also exchanges its contents with the low byte of a 16-bit accumulator/flag pair:
- it is always readable as a packed byte;
- it can be overwritten from such a byte, as when that pair is restored from a stack.

A keep-carry control lets single-step increment and decrement reuse the adder without disturbing the stored carry.

Top module: `alu8_unit`

## Requirements
- R1: Operation code values are 0=add, 1=add-with-carry, 2=subtract, 3=subtract-with-carry, 4=AND, 5=XOR, 6=OR, 7=compare. For add and add-with-carry, the result is the low 8 bits of the sum, and carry is the carry out of bit 7.
- R2: The `carry_in` input is added to the right operand only for codes 1 and 3. For every other code it has no effect on the result or the flags.
- R3: For codes 2, 3 and 7, the result is left minus (right plus effective carry-in), modulo 256. Carry is set when (right + effective carry-in) exceeds left, i.e. on a borrow out of bit 7.
- R4: Half-carry for arithmetic codes is the carry (add) or borrow (subtract) out of bit 3. It is computed from the low nibbles plus the effective carry-in.
- R5: AND sets half-carry and clears carry. XOR and OR clear both half-carry and carry.
- R6: The subtract flag is set for codes 2, 3 and 7 and cleared for all other codes.
- R7: Compare (code 7) drives `result_we` low and produces the same flags as subtract. Every other code drives `result_we` high.
- R8: The zero flag is set exactly when the 8-bit result is 0x00.
- R9: While `keep_carry` is high, an update leaves the stored carry at its previous value, and the other three flags update normally.
- R10: `flag_byte_out` packs zero in bit 7, subtract in bit 6, half-carry in bit 5 and carry in bit 4, and bits 3:0 always read 0. `flag_load` loads the flags from bits 7:4 of `flag_byte_in`, ignores bits 3:0, and takes priority over `flag_en`.
- R11: Synchronous reset clears all flags. Flags change only on a clock edge where `flag_en` or `flag_load` is high, and the new values appear after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_sel | input | 3 | Operation code |
| lhs | input | 8 | Left operand (accumulator) |
| rhs | input | 8 | Right operand |
| carry_in | input | 1 | Incoming carry for codes 1 and 3 |
| keep_carry | input | 1 | Preserve stored carry on update |
| flag_en | input | 1 | Capture computed flags at the clock edge |
| flag_load | input | 1 | Load flags from `flag_byte_in` |
| flag_byte_in | input | 8 | Packed flag byte to load |
| result | output | 8 | Combinational result |
| result_we | output | 1 | Result should be written back |
| z_flag | output | 1 | Stored zero flag |
| n_flag | output | 1 | Stored subtract flag |
| h_flag | output | 1 | Stored half-carry flag |
| c_flag | output | 1 | Stored carry flag |
| flag_byte_out | output | 8 | Stored flags in packed form |

## Verification
`result` and `result_we` are combinational, so the bench drives a stimulus just after a falling edge and samples them one time unit later, with no clock edge in between. The flags are due only after the next rising edge. The bench therefore samples them at the following falling edge, compares them against a reference flag value it maintains itself, and then updates that reference. The stimulus is mixed:
- seeded random operands and operation codes;
- directed cases for nibble and byte boundaries, compare with equal operands, keep-carry, the load priority and holding with both enables low.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

    parameter int DATA_W = 8;
    parameter int NIB_W  = DATA_W / 2;

    typedef enum logic [2:0] {
        OP_ADD = 3'd0,
        OP_ADC = 3'd1,
        OP_SUB = 3'd2,
        OP_SBC = 3'd3,
        OP_AND = 3'd4,
        OP_XOR = 3'd5,
        OP_OR  = 3'd6,
        OP_CMP = 3'd7
    } alu_op_e;

    typedef struct packed {
        logic z;
        logic n;
        logic h;
        logic c;
    } flags_t;

    function automatic logic [7:0] pack_flags(flags_t f);
        return {f.z, f.n, f.h, f.c, 4'b0000};
    endfunction

    function automatic flags_t unpack_flags(logic [7:0] b);
        flags_t f;
        f.z = b[7];
        f.n = b[6];
        f.h = b[5];
        f.c = b[4];
        return f;
    endfunction

    function automatic logic is_subtractive(alu_op_e op);
        return (op == OP_SUB) || (op == OP_SBC) || (op == OP_CMP);
    endfunction

    function automatic logic uses_carry(alu_op_e op);
        return (op == OP_ADC) || (op == OP_SBC);
    endfunction

endpackage

// File: rtl/alu8_core.sv
module alu8_core
    import alu8_pkg::*;
(
    input  alu_op_e             op,
    input  logic [DATA_W-1:0]   lhs,
    input  logic [DATA_W-1:0]   rhs,
    input  logic                carry_in,
    input  logic                keep_carry,
    input  logic                old_carry,
    output logic [DATA_W-1:0]   result,
    output logic                result_we,
    output flags_t              nxt
);

    logic              cin_eff;
    logic [NIB_W:0]    lo_add, lo_sub, cin_lo;
    logic [DATA_W:0]   hi_add, hi_sub, cin_hi;
    logic              h_raw, c_raw;

    assign cin_eff = carry_in && uses_carry(op);
    assign cin_lo  = {{NIB_W{1'b0}}, cin_eff};
    assign cin_hi  = {{DATA_W{1'b0}}, cin_eff};

    assign lo_add = {1'b0, lhs[NIB_W-1:0]} + {1'b0, rhs[NIB_W-1:0]} + cin_lo;
    assign lo_sub = {1'b0, lhs[NIB_W-1:0]} - {1'b0, rhs[NIB_W-1:0]} - cin_lo;
    assign hi_add = {1'b0, lhs} + {1'b0, rhs} + cin_hi;
    assign hi_sub = {1'b0, lhs} - {1'b0, rhs} - cin_hi;

    always_comb begin
        result = '0;
        h_raw  = 1'b0;
        c_raw  = 1'b0;
        unique case (op)
            OP_ADD, OP_ADC: begin
                result = hi_add[DATA_W-1:0];
                h_raw  = lo_add[NIB_W];
                c_raw  = hi_add[DATA_W];
            end
            OP_SUB, OP_SBC, OP_CMP: begin
                result = hi_sub[DATA_W-1:0];
                h_raw  = lo_sub[NIB_W];
                c_raw  = hi_sub[DATA_W];
            end
            OP_AND: begin
                result = lhs & rhs;
                h_raw  = 1'b1;
            end
            OP_XOR: result = lhs ^ rhs;
            OP_OR:  result = lhs | rhs;
            default: result = '0;
        endcase
    end

    assign result_we = (op != OP_CMP);
    assign nxt.z     = (result == '0);
    assign nxt.n     = is_subtractive(op);
    assign nxt.h     = h_raw;
    assign nxt.c     = keep_carry ? old_carry : c_raw;

    // R7: compare never requests write-back
    always_comb begin
        if (op == OP_CMP)
            a_r7_cmp_no_write: assert (!result_we);
    end

endmodule

// File: rtl/alu8_flag_reg.sv
module alu8_flag_reg
    import alu8_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        upd_en,
    input  logic        load_en,
    input  logic [7:0]  load_byte,
    input  flags_t      nxt,
    output flags_t      q
);

    always_ff @(posedge clk) begin
        if (rst)
            q <= '0;
        else if (load_en)
            q <= unpack_flags(load_byte);
        else if (upd_en)
            q <= nxt;
    end

    // R11: reset clears all flags
    a_r11_reset_clear: assert property (@(posedge clk) rst |=> (q == '0));

    // R11: no enable, no change
    a_r11_hold: assert property (@(posedge clk) disable iff (rst)
        (!upd_en && !load_en) |=> $stable(q));

    // R10: load takes priority and copies the upper nibble
    a_r10_load_wins: assert property (@(posedge clk) disable iff (rst)
        load_en |=> (q == unpack_flags($past(load_byte))));

endmodule

// File: rtl/alu8_unit.sv
module alu8_unit
    import alu8_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic [2:0]  op_sel,
    input  logic [7:0]  lhs,
    input  logic [7:0]  rhs,
    input  logic        carry_in,
    input  logic        keep_carry,
    input  logic        flag_en,
    input  logic        flag_load,
    input  logic [7:0]  flag_byte_in,
    output logic [7:0]  result,
    output logic        result_we,
    output logic        z_flag,
    output logic        n_flag,
    output logic        h_flag,
    output logic        c_flag,
    output logic [7:0]  flag_byte_out
);

    alu_op_e op;
    flags_t  nxt_flags;
    flags_t  cur_flags;

    assign op = alu_op_e'(op_sel);

    alu8_core u_core (
        .op         (op),
        .lhs        (lhs),
        .rhs        (rhs),
        .carry_in   (carry_in),
        .keep_carry (keep_carry),
        .old_carry  (cur_flags.c),
        .result     (result),
        .result_we  (result_we),
        .nxt        (nxt_flags)
    );

    alu8_flag_reg u_flags (
        .clk       (clk),
        .rst       (rst),
        .upd_en    (flag_en),
        .load_en   (flag_load),
        .load_byte (flag_byte_in),
        .nxt       (nxt_flags),
        .q         (cur_flags)
    );

    assign z_flag        = cur_flags.z;
    assign n_flag        = cur_flags.n;
    assign h_flag        = cur_flags.h;
    assign c_flag        = cur_flags.c;
    assign flag_byte_out = pack_flags(cur_flags);

    // R10: packed low nibble always reads zero
    a_r10_low_nibble_zero: assert property (@(posedge clk) disable iff (rst)
        flag_byte_out[3:0] == 4'h0);

    // R9: keep-carry preserves the stored carry
    a_r9_keep_carry: assert property (@(posedge clk) disable iff (rst)
        (flag_en && !flag_load && keep_carry) |=> (c_flag == $past(c_flag)));

    // R8: zero flag follows the result that was captured
    a_r8_zero: assert property (@(posedge clk) disable iff (rst)
        (flag_en && !flag_load) |=> (z_flag == ($past(result) == 8'h00)));

    // R5: AND leaves half-carry set
    a_r5_and_half: assert property (@(posedge clk) disable iff (rst)
        (flag_en && !flag_load && op_sel == 3'd4) |=> h_flag);

    // R6: compare sets the subtract flag
    a_r6_cmp_sub: assert property (@(posedge clk) disable iff (rst)
        (flag_en && !flag_load && op_sel == 3'd7) |=> n_flag);

endmodule

// File: tb/alu8_unit_bench.sv
module alu8_unit_bench;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 100000;

    logic       clk = 1'b0;
    logic       rst;
    logic [2:0] op_sel;
    logic [7:0] lhs, rhs, flag_byte_in;
    logic       carry_in, keep_carry, flag_en, flag_load;
    logic [7:0] result, flag_byte_out;
    logic       result_we, z_flag, n_flag, h_flag, c_flag;

    int checks   = 0;
    int failures = 0;
    int cycles   = 0;
    logic [7:0] exp_flags;

    always #(CLK_PERIOD/2) clk = ~clk;

    alu8_unit u_alu8_unit (
        .clk(clk), .rst(rst), .op_sel(op_sel), .lhs(lhs), .rhs(rhs),
        .carry_in(carry_in), .keep_carry(keep_carry), .flag_en(flag_en),
        .flag_load(flag_load), .flag_byte_in(flag_byte_in),
        .result(result), .result_we(result_we), .z_flag(z_flag),
        .n_flag(n_flag), .h_flag(h_flag), .c_flag(c_flag),
        .flag_byte_out(flag_byte_out)
    );

    // returns {result, packed flags} as the requirements define them
    function automatic logic [15:0] model(input logic [2:0] op, input logic [7:0] a,
                                          input logic [7:0] b, input logic cin,
                                          input logic kc, input logic old_c);
        int ci, s, lo;
        logic [7:0] r;
        logic z, n, h, c;
        ci = ((op == 3'd1 || op == 3'd3) && cin) ? 1 : 0;
        h = 0; c = 0; r = 0;
        case (op)
            3'd0, 3'd1: begin
                s = int'(a) + int'(b) + ci; lo = int'(a & 8'hF) + int'(b & 8'hF) + ci;
                r = 8'(s); c = (s > 255); h = (lo > 15);
            end
            3'd2, 3'd3, 3'd7: begin
                s = int'(a) - int'(b) - ci; lo = int'(a & 8'hF) - int'(b & 8'hF) - ci;
                r = 8'(s & 255); c = (s < 0); h = (lo < 0);
            end
            3'd4: begin r = a & b; h = 1; end
            3'd5: r = a ^ b;
            default: r = a | b;
        endcase
        n = (op == 3'd2 || op == 3'd3 || op == 3'd7);
        z = (r == 8'h00);
        if (kc) c = old_c;
        return {r, z, n, h, c, 4'h0};
    endfunction

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    function automatic string tag_of(input logic [2:0] op);
        case (op)
            3'd0: return "R1 add";
            3'd1: return "R2 adc";
            3'd2: return "R3 sub";
            3'd3: return "R3 sbc";
            3'd4: return "R5 and";
            3'd5: return "R5 xor";
            3'd6: return "R5 or";
            default: return "R7 cmp";
        endcase
    endfunction

    task automatic apply(input logic [2:0] op, input logic [7:0] a, input logic [7:0] b,
                         input logic cin, input logic kc, input logic en,
                         input logic ld, input logic [7:0] ldb, input string tag);
        logic [15:0] m;
        @(negedge clk);
        op_sel = op; lhs = a; rhs = b; carry_in = cin; keep_carry = kc;
        flag_en = en; flag_load = ld; flag_byte_in = ldb;
        m = model(op, a, b, cin, kc, exp_flags[4]);
        #1;
        check({tag, " result"}, result, m[15:8]);
        check("R7 result_we", {7'b0, result_we}, {7'b0, op != 3'd7});
        if (ld)      exp_flags = ldb & 8'hF0;
        else if (en) exp_flags = m[7:0];
        @(negedge clk);
        check({tag, " flags"}, flag_byte_out, exp_flags);
        check("R10 flag pins", {z_flag, n_flag, h_flag, c_flag, 4'h0}, flag_byte_out);
        flag_en = 0; flag_load = 0;
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > WATCHDOG) begin
                failures++;
                $display("FAIL watchdog expired");
                $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
                $finish;
            end
        end
    end

    initial begin
        int seed;
        seed = 32'h5eed_0042;
        void'($urandom(seed));
        rst = 1; op_sel = 0; lhs = 0; rhs = 0; carry_in = 0; keep_carry = 0;
        flag_en = 0; flag_load = 0; flag_byte_in = 0; exp_flags = 8'h00;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R11 reset flags", flag_byte_out, 8'h00);
        rst = 0;

        // directed corners
        apply(3'd0, 8'h0F, 8'h01, 0, 0, 1, 0, 0, "R4 nibble carry");
        apply(3'd0, 8'hFF, 8'h01, 0, 0, 1, 0, 0, "R8 add wrap zero");
        apply(3'd0, 8'h10, 8'h20, 1, 0, 1, 0, 0, "R2 add ignores cin");
        apply(3'd1, 8'hFF, 8'h00, 1, 0, 1, 0, 0, "R2 adc cin wrap");
        apply(3'd3, 8'h00, 8'h00, 1, 0, 1, 0, 0, "R3 sbc borrow");
        apply(3'd3, 8'h10, 8'h0F, 1, 0, 1, 0, 0, "R4 sbc nibble");
        apply(3'd7, 8'h42, 8'h42, 0, 0, 1, 0, 0, "R7 cmp equal");
        apply(3'd7, 8'h10, 8'h20, 0, 0, 1, 0, 0, "R6 cmp borrow");
        apply(3'd4, 8'hF0, 8'h0F, 0, 0, 1, 0, 0, "R5 and zero");
        apply(3'd6, 8'h00, 8'h00, 0, 0, 1, 0, 0, "R5 or zero");
        apply(3'd0, 8'hFF, 8'h01, 0, 1, 1, 0, 0, "R9 keep carry clear");
        apply(3'd0, 8'hF0, 8'h20, 0, 0, 1, 0, 0, "R1 carry out");
        apply(3'd2, 8'h01, 8'h01, 0, 1, 1, 0, 0, "R9 keep carry set");
        apply(3'd5, 8'h55, 8'h55, 0, 0, 1, 1, 8'h5A, "R10 load wins");
        apply(3'd0, 8'h00, 8'h00, 0, 0, 0, 1, 8'hFF, "R10 load all");
        apply(3'd0, 8'h00, 8'h00, 0, 0, 0, 0, 0, "R11 hold");

        for (int i = 0; i < 400; i++) begin
            logic [2:0] op;
            op = 3'($urandom);
            apply(op, 8'($urandom), 8'($urandom), 1'($urandom),
                  ($urandom % 8) == 0, ($urandom % 6) != 0,
                  ($urandom % 20) == 0, 8'($urandom), tag_of(op));
        end

        rst = 1;
        @(negedge clk);
        rst = 0;
        check("R11 reset again", flag_byte_out, 8'h00);

        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule